// File: doc/BRIEF.md
# Hot-swap bus connect controller

This controller decides when the two-wire bus on a plug-in card may be joined to a two-wire bus that is already live on a backplane. It watches four line levels: data and clock on the backplane side and data and clock on the card side. It also watches an active-high enable and a power-good input. From these it drives three outputs: a connect strobe for the external pass path, a precharge flag for the external line precharge, and an active-high ready flag.

After enable is seen high, the controller runs an initialisation interval of a fixed number of clock cycles. Only after that interval does it start watching the bus. It joins the two sides on the first of two conditions:

- all four lines have stayed high for a full bus-idle interval, or
- the backplane shows a stop condition (data rising while clock is high) and both card lines are high.

Once joined, the sides stay joined until enable or power-good goes low. Both interval lengths are set in microseconds and turned into cycle counts from the clock frequency. The line inputs are asynchronous and pass through two-flop synchronisers.

Top module: `hs_conn_ctrl`

## Requirements
- R1: While `pwr_ok` is low, all three outputs are low. The drop of `pwr_ok` forces the disabled state asynchronously, without waiting for a clock edge.
- R2: While `en` is low, `link_on`, `ready` and `prechg_en` are all low in the same cycle. The outputs are gated without a register in the path.
- R3: After `en` is sampled high, an initialisation interval of EN_CYC clock cycles runs. The interval lasts from the first edge after `en` rises until edge EN_CYC+1. During it no line condition is acted on, and a backplane stop condition seen inside it never connects.
- R4: `prechg_en` is high from the start of initialisation until the cycle the connection is made, and falls in that same cycle. `prechg_en` and `link_on` are never high together.
- R5: After initialisation, if all four synchronised lines stay high for IDLE_CYC consecutive cycles, the sides are connected. With lines already high, `link_on` rises at clock edge EN_CYC+IDLE_CYC+2 after `en` is sampled high.
- R6: During the watch phase, a low on any of the four lines restarts the idle count from zero. The full idle interval must then pass again after the lines return high.
- R7: During the watch phase, a backplane stop condition connects the sides within four cycles of the backplane data rising, without waiting for the idle interval. A stop condition is backplane data going from 0 to 1 while backplane clock is 1, with both card lines at 1.
- R8: A backplane stop condition while either card line is low does not connect.
- R9: `ready` is high exactly when the sides are connected. It is low during disable, initialisation and watch.
- R10: Once connected, `link_on` stays high through any line activity for as long as `en` and `pwr_ok` stay high.
- R11: Raising `en` again after a disable starts a fresh initialisation. There is no immediate reconnection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| pwr_ok | input | 1 | Power-good; low resets the controller asynchronously to the disabled state |
| en | input | 1 | Active-high enable, synchronous to `clk` |
| bp_sda | input | 1 | Backplane data line level, asynchronous |
| bp_scl | input | 1 | Backplane clock line level, asynchronous |
| cd_sda | input | 1 | Card data line level, asynchronous |
| cd_scl | input | 1 | Card clock line level, asynchronous |
| link_on | output | 1 | Connect strobe for the backplane-to-card pass path |
| prechg_en | output | 1 | Enable for the external line precharge |
| ready | output | 1 | High while the two sides are connected |

## Verification
The bench builds the controller with CLK_KHZ set to 1000 and the default interval lengths. This gives EN_CYC = 110 and IDLE_CYC = 105 cycles. At that size every phase boundary can be reached, and the expected cycle of each transition can be checked exactly, both just before and just after it. The same size leaves room for idle-restart, stop-inside-initialisation and repeated re-enable sequences in one short run. With the default clock the intervals would be hundreds of times longer, but the same arithmetic applies.

// File: rtl/hs_conn_pkg.sv
package hs_conn_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_INIT  = 2'd1,
        ST_WATCH = 2'd2,
        ST_LINK  = 2'd3
    } hs_state_e;

    // Bit positions of the synchronised line vector
    localparam int unsigned LN_BP_SDA = 0;
    localparam int unsigned LN_BP_SCL = 1;
    localparam int unsigned LN_CD_SDA = 2;
    localparam int unsigned LN_CD_SCL = 3;
    localparam int unsigned NUM_LINES = 4;

    // Microseconds to clock cycles, never below one
    function automatic int unsigned us_to_cycles(input int unsigned khz,
                                                 input int unsigned us);
        int unsigned n;
        n = (khz * us) / 1000;
        return (n == 0) ? 1 : n;
    endfunction

endpackage

// File: rtl/hs_line_sync.sv
module hs_line_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], raw_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/hs_bus_watch.sv
module hs_bus_watch
    import hs_conn_pkg::*;
#(
    parameter int unsigned IDLE_CYC = 105
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 armed_i,
    input  logic [NUM_LINES-1:0] lines_i,
    output logic                 idle_done_o,
    output logic                 stop_ok_o
);

    localparam int unsigned CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] CNT_END = CW'(IDLE_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sda_prev;
        logic          scl_prev;
    } watch_t;

    watch_t w_d, w_q;
    logic   all_hi;
    logic   card_hi;

    always_comb begin
        all_hi   = &lines_i;
        card_hi  = lines_i[LN_CD_SDA] & lines_i[LN_CD_SCL];
        w_d          = w_q;
        w_d.sda_prev = lines_i[LN_BP_SDA];
        w_d.scl_prev = lines_i[LN_BP_SCL];
        if (!armed_i || !all_hi) begin
            w_d.cnt = '0;
        end else if (w_q.cnt != CNT_END) begin
            w_d.cnt = w_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign idle_done_o = armed_i && (w_q.cnt == CNT_END);

    // Backplane data rises while its clock stays high, card side idle
    assign stop_ok_o = armed_i && !w_q.sda_prev && lines_i[LN_BP_SDA]
                     && w_q.scl_prev && lines_i[LN_BP_SCL] && card_hi;

    // Any low line in the watch phase clears the idle count
    p_idle_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && !(&lines_i)) |=> (w_q.cnt == '0));

    // Idle completion only after the lines were high in the previous cycle
    p_idle_needs_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && $past(armed_i) && idle_done_o) |-> $past(&lines_i));

endmodule

// File: rtl/hs_conn_seq.sv
module hs_conn_seq
    import hs_conn_pkg::*;
#(
    parameter int unsigned EN_CYC = 110
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      idle_done_i,
    input  logic      stop_ok_i,
    output hs_state_e state_o,
    output logic      armed_o
);

    localparam int unsigned TW = $clog2(EN_CYC + 1);
    localparam logic [TW-1:0] TMR_END = TW'(EN_CYC - 1);

    typedef struct packed {
        hs_state_e     state;
        logic [TW-1:0] tmr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en_i) begin
            s_d.state = ST_OFF;
            s_d.tmr   = '0;
        end else begin
            unique case (s_q.state)
                ST_OFF: begin
                    s_d.state = ST_INIT;
                    s_d.tmr   = '0;
                end
                ST_INIT: begin
                    if (s_q.tmr == TMR_END) begin
                        s_d.state = ST_WATCH;
                        s_d.tmr   = '0;
                    end else begin
                        s_d.tmr = s_q.tmr + 1'b1;
                    end
                end
                ST_WATCH: begin
                    if (idle_done_i || stop_ok_i) s_d.state = ST_LINK;
                end
                ST_LINK: begin
                    s_d.state = ST_LINK;
                end
                default: s_d.state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_OFF, tmr: '0};
        else        s_q <= s_d;
    end

    assign state_o = s_q.state;
    assign armed_o = (s_q.state == ST_WATCH);

    // Initialisation never jumps straight to the linked state
    p_init_no_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_INIT) |=> (s_q.state != ST_LINK));

    // The linked state is entered only from the watch phase
    p_link_from_watch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_LINK && $past(s_q.state) != ST_LINK)
            |-> ($past(s_q.state) == ST_WATCH));

endmodule

// File: rtl/hs_conn_ctrl.sv
module hs_conn_ctrl
    import hs_conn_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 250000,
    parameter int unsigned EN_US   = 110,
    parameter int unsigned IDLE_US = 105
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic en,
    input  logic bp_sda,
    input  logic bp_scl,
    input  logic cd_sda,
    input  logic cd_scl,
    output logic link_on,
    output logic prechg_en,
    output logic ready
);

    localparam int unsigned EN_CYC   = us_to_cycles(CLK_KHZ, EN_US);
    localparam int unsigned IDLE_CYC = us_to_cycles(CLK_KHZ, IDLE_US);

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] sync_lines;
    logic                 armed;
    logic                 idle_done;
    logic                 stop_ok;
    hs_state_e            state;

    always_comb begin
        raw_lines            = '0;
        raw_lines[LN_BP_SDA] = bp_sda;
        raw_lines[LN_BP_SCL] = bp_scl;
        raw_lines[LN_CD_SDA] = cd_sda;
        raw_lines[LN_CD_SCL] = cd_scl;
    end

    hs_line_sync #(.WIDTH(NUM_LINES), .STAGES(2)) i_sync (
        .clk    (clk),
        .rst_n  (pwr_ok),
        .raw_i  (raw_lines),
        .sync_o (sync_lines)
    );

    hs_bus_watch #(.IDLE_CYC(IDLE_CYC)) i_watch (
        .clk         (clk),
        .rst_n       (pwr_ok),
        .armed_i     (armed),
        .lines_i     (sync_lines),
        .idle_done_o (idle_done),
        .stop_ok_o   (stop_ok)
    );

    hs_conn_seq #(.EN_CYC(EN_CYC)) i_seq (
        .clk         (clk),
        .rst_n       (pwr_ok),
        .en_i        (en),
        .idle_done_i (idle_done),
        .stop_ok_i   (stop_ok),
        .state_o     (state),
        .armed_o     (armed)
    );

    // Enable gates the registered state directly, so a drop takes effect at once
    assign link_on   = en && (state == ST_LINK);
    assign ready     = en && (state == ST_LINK);
    assign prechg_en = en && ((state == ST_INIT) || (state == ST_WATCH));

    p_en_low_quiet_r2: assert property (@(posedge clk) disable iff (!pwr_ok)
        !en |-> (!link_on && !ready && !prechg_en));

    p_prechg_excl_r4: assert property (@(posedge clk) disable iff (!pwr_ok)
        !(prechg_en && link_on));

    p_link_after_prechg_r4: assert property (@(posedge clk) disable iff (!pwr_ok)
        ($rose(link_on) && $past(en)) |-> $past(prechg_en));

    p_ready_tracks_link_r9: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(ready) |-> $past(prechg_en));

    p_hold_link_r10: assert property (@(posedge clk) disable iff (!pwr_ok)
        (en && $past(link_on && en)) |-> link_on);

    p_reenable_fresh_r11: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(en) |-> !link_on);

endmodule

// File: tb/test_hs_conn_ctrl.sv
`timescale 1ns/1ps
module test_hs_conn_ctrl;

    localparam int unsigned EN_CYC   = 110;
    localparam int unsigned IDLE_CYC = 105;

    logic clk = 1'b0;
    logic pwr_ok, en, bp_sda, bp_scl, cd_sda, cd_scl;
    logic link_on, prechg_en, ready;
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    always #2 clk = ~clk;

    hs_conn_ctrl #(.CLK_KHZ(1000), .EN_US(110), .IDLE_US(105)) i_hs_conn_ctrl (
        .clk       (clk),
        .pwr_ok    (pwr_ok),
        .en        (en),
        .bp_sda    (bp_sda),
        .bp_scl    (bp_scl),
        .cd_sda    (cd_sda),
        .cd_scl    (cd_scl),
        .link_on   (link_on),
        .prechg_en (prechg_en),
        .ready     (ready)
    );

    // Observed vector {link_on, ready, prechg_en}
    task automatic chk(input string tag, input logic [2:0] exp);
        logic [2:0] act;
        act = {link_on, ready, prechg_en};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {link,ready,prechg} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lines(input logic bs, input logic bc, input logic cs, input logic cc);
        bp_sda = bs; bp_scl = bc; cd_sda = cs; cd_scl = cc;
    endtask

    task automatic go_off();
        en = 1'b0;
        lines(1, 1, 1, 1);
        wcyc(4);
    endtask

    task automatic t_reset();
        pwr_ok = 1'b0; en = 1'b0;
        lines(1, 1, 1, 1);
        wcyc(3);
        chk("R1 outputs low in reset", 3'b000);
        pwr_ok = 1'b1;
        wcyc(3);
        chk("R2 enable low after reset", 3'b000);
    endtask

    task automatic t_idle_connect();
        go_off();
        en = 1'b1;
        wcyc(2);
        chk("R3 initialisation precharge, not ready", 3'b001);
        wcyc(EN_CYC + IDLE_CYC - 4);
        chk("R5 not linked just before idle end", 3'b001);
        wcyc(6);
        chk("R5 linked after idle interval", 3'b110);
        chk("R9 ready with link", 3'b110);
        chk("R4 precharge dropped at link", 3'b110);
    endtask

    task automatic t_stay_linked();
        // starts linked
        lines(0, 0, 0, 1);
        wcyc(100);
        lines(1, 0, 1, 0);
        wcyc(100);
        chk("R10 link held through bus activity", 3'b110);
        lines(1, 1, 1, 1);
    endtask

    task automatic t_disable_reenable();
        // starts linked
        en = 1'b0;
        #1;
        chk("R2 enable drop clears outputs at once", 3'b000);
        wcyc(2);
        en = 1'b1;
        wcyc(3);
        chk("R11 re-enable restarts initialisation", 3'b001);
        wcyc(EN_CYC + IDLE_CYC + 2);
        chk("R11 link only after full sequence", 3'b110);
    endtask

    task automatic t_idle_restart();
        go_off();
        en = 1'b1;
        wcyc(EN_CYC + 50);
        cd_scl = 1'b0;
        wcyc(5);
        cd_scl = 1'b1;
        wcyc(IDLE_CYC - 3);
        chk("R6 idle count restarted by card clock low", 3'b001);
        wcyc(9);
        chk("R6 link after fresh idle interval", 3'b110);
    endtask

    task automatic t_stop_connect();
        go_off();
        lines(0, 1, 1, 1);
        en = 1'b1;
        wcyc(EN_CYC + 10);
        chk("R7 waiting in watch with backplane data low", 3'b001);
        bp_sda = 1'b1;
        wcyc(6);
        chk("R7 stop condition links early", 3'b110);
    endtask

    task automatic t_stop_card_low();
        go_off();
        lines(0, 1, 0, 1);
        en = 1'b1;
        wcyc(EN_CYC + 10);
        bp_sda = 1'b1;
        wcyc(8);
        chk("R8 stop with card data low ignored", 3'b001);
        lines(0, 1, 1, 0);
        wcyc(4);
        bp_sda = 1'b1;
        wcyc(8);
        chk("R8 stop with card clock low ignored", 3'b001);
    endtask

    task automatic t_stop_in_init();
        go_off();
        lines(0, 1, 1, 1);
        en = 1'b1;
        wcyc(20);
        bp_sda = 1'b1;
        wcyc(10);
        chk("R3 stop during initialisation ignored", 3'b001);
        wcyc(EN_CYC - 20);
        chk("R3 no link just after initialisation", 3'b001);
        wcyc(IDLE_CYC + 4);
        chk("R5 idle link after ignored stop", 3'b110);
    endtask

    task automatic t_init_abort();
        go_off();
        en = 1'b1;
        wcyc(30);
        chk("R4 precharge during initialisation", 3'b001);
        en = 1'b0;
        #1;
        chk("R4 precharge drops with enable", 3'b000);
        wcyc(3);
    endtask

    task automatic t_pwr_drop();
        // starts linked
        pwr_ok = 1'b0;
        #1;
        chk("R1 power drop clears outputs", 3'b000);
        wcyc(3);
        pwr_ok = 1'b1;
        wcyc(3);
        chk("R1 restart from disabled after power", 3'b001);
    endtask

    initial begin
        t_reset();
        t_idle_connect();
        t_stay_linked();
        t_disable_reenable();
        t_idle_restart();
        t_stop_connect();
        t_pwr_drop();
        t_stop_card_low();
        t_stop_in_init();
        t_init_abort();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule